// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

This block is a 16-bit up-counter for a peripheral bus. It runs in one of three ways. As a timer it counts an internal tick at the instruction rate, which is the system clock divided by four. As a synchronous counter it counts rising edges of an external input after they pass through a two-flop synchronizer. As an asynchronous counter it counts rising edges of the same input taken straight from the pin, with no synchronizer. A prescaler divides the chosen source by 1, 2, 4 or 8. An enable bit gates counting. A clear strobe from a compare unit zeroes the count. When the count wraps from all ones to zero it sets a sticky overflow flag.

Software reaches the block over an 8-bit bus with four addresses: control, count low byte, count high byte and status. In buffered mode a high-byte buffer makes 16-bit accesses atomic. Reading the low byte snapshots the high byte into the buffer. Writing the low byte loads both halves of the count at once.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, the control register and the overflow flag are zero, all four addresses read 0x00, and `ovfIrq` is low.
- R2: Internal timer mode (control bit1 = 0, bit0 = 1): the count advances once every 4*d system clocks, where d = 2^(bits[3:2]). A write to the count restarts the phase divider and the prescaler, so n clocks after the write edge the count is the written value plus floor(n/(4*d)).
- R3: While control bit0 (enable) is 0, the count holds its value.
- R4: Synchronized external mode (bit1 = 1, bit4 = 0, d = 1): a rising edge of `extIn` that is first sampled at clock edge A advances the count at edge A+2, and not before.
- R5: Direct external mode (bit1 = 1, bit4 = 1, d = 1): the count advances at the first clock edge that samples `extIn` high after it was low.
- R6: In external modes the count advances on every d-th rising edge of `extIn`, counting from the last write to the count.
- R7: `cmpClear` high at a clock edge sets the count to zero at that edge, and takes priority over an increment. A bus write to the count at the same edge takes priority over the clear.
- R8: When an increment takes the count from 0xFFFF to 0x0000, the overflow flag (status bit0 at address 3, also driven on `ovfIrq`) is set. The flag stays set until a write to address 3 with bit0 = 1. Writes with bit0 = 0 leave it alone. If an overflow and a clearing write happen at the same edge, the flag ends up set.
- R9: Buffered mode (bit5 = 1): a read of address 1 with `busRd` high copies the live high byte into the buffer at that edge. Address 2 then reads the buffer, not the live byte.
- R10: Buffered mode: a write to address 2 changes only the buffer. A write to address 1 loads the count with {buffer, data} at one edge.
- R11: Direct mode (bit5 = 0): address 2 reads and writes the live high byte, and a write to address 1 changes only the low byte.
- R12: Address 0 reads back control bits [5:0] as written. Bits [7:6] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIn | input | 1 | External count input |
| cmpClear | input | 1 | Count clear strobe from the compare unit |
| busAddr | input | 2 | Register address: 0 control, 1 count low, 2 count high, 3 status |
| busWr | input | 1 | Write strobe, takes effect at the clock edge |
| busRd | input | 1 | Read strobe; needed only for the buffer snapshot |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| ovfIrq | output | 1 | Overflow flag |

## Verification
Every bus write takes effect at the clock edge it is set up for. The bench drives each access half a cycle ahead of that edge and samples read data combinationally half a cycle after later edges, so the offsets it counts run from the write edge itself. In timer mode the expected value n edges after the write is floor(n/(4*d)), and the sweep samples just before and at each step for every prescaler setting. In external modes the bench places the rising edge just before a known edge A. It then expects the count to move at A in direct mode and at A+2 through the synchronizer, and checks that nothing has changed at A and A+1. Clear, overflow and flag priorities are set up to coincide at a single edge, and the effect is read at the next sample.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
  localparam int BUS_W  = 8;
  localparam int CNT_W  = 2 * BUS_W;
  localparam int PS_W   = 2;
  localparam int PRE_W  = (1 << PS_W) - 1;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // control register layout, bit order is software visible
  typedef struct packed {
    logic            rw16;
    logic            noSync;
    logic [PS_W-1:0] psSel;
    logic            extSel;
    logic            en;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic inc;
    logic clr;
    logic wrLo;
    logic wrHi;
    logic loadFull;
    logic wrBuf;
    logic capBuf;
    logic flagClr;
  } dpStrobe_t;
endpackage

// File: rtl/evt_timer16_ctrl.sv
module evt_timer16_ctrl
  import evt_timer16_pkg::*;
#(
  parameter int CYC_DIV = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extIn,
  input  logic              cmpClear,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CTRL_W-1:0] busWbits,
  output ctrlReg_t          ctrlQ,
  output dpStrobe_t         strb
);
  localparam int PH_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_DIV - 1);

  logic ctrlWr, cntWr;
  logic [PH_W-1:0] phase;
  logic intTick;
  logic [SYNC_N-1:0] syncQ;
  logic syncPrev, rawPrev;
  logic syncEdge, rawEdge, extEdge, srcTick;
  logic [PRE_W-1:0] preCnt, divMask;
  logic fire;

  assign ctrlWr = busWr && (busAddr == ADDR_CTRL);
  assign cntWr  = busWr && ((busAddr == ADDR_LO) ||
                            ((busAddr == ADDR_HI) && !ctrlQ.rw16));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= ctrlReg_t'(busWbits);
  end

  // instruction-rate phase divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (cntWr || phase == PH_LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end
  assign intTick = (phase == PH_LAST);

  // synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else syncQ[0] <= extIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      rawPrev  <= 1'b0;
    end else begin
      syncPrev <= syncQ[SYNC_N-1];
      rawPrev  <= extIn;
    end
  end

  assign syncEdge = syncQ[SYNC_N-1] && !syncPrev;
  assign rawEdge  = extIn && !rawPrev;
  assign extEdge  = ctrlQ.noSync ? rawEdge : syncEdge;
  assign srcTick  = ctrlQ.extSel ? extEdge : intTick;

  // prescaler: mask has psSel low ones
  assign divMask = ~({PRE_W{1'b1}} << ctrlQ.psSel);
  assign fire    = ctrlQ.en && srcTick && ((preCnt & divMask) == divMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (cntWr || cmpClear) preCnt <= '0;
    else if (ctrlQ.en && srcTick) preCnt <= fire ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    strb          = '0;
    strb.inc      = fire && !cntWr && !cmpClear;
    strb.clr      = cmpClear && !cntWr;
    strb.wrLo     = busWr && (busAddr == ADDR_LO);
    strb.loadFull = busWr && (busAddr == ADDR_LO) && ctrlQ.rw16;
    strb.wrHi     = busWr && (busAddr == ADDR_HI) && !ctrlQ.rw16;
    strb.wrBuf    = busWr && (busAddr == ADDR_HI) && ctrlQ.rw16;
    strb.capBuf   = busRd && (busAddr == ADDR_LO) && ctrlQ.rw16;
    strb.flagClr  = busWr && (busAddr == ADDR_STAT) && busWbits[0];
  end

  // R4
  sync_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && ctrlQ.extSel && !ctrlQ.noSync) |-> $past(extIn, 2));

  // R5
  direct_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && ctrlQ.extSel && ctrlQ.noSync) |-> extIn);

  // R3
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ.en && !ctrlWr) |=> !strb.inc);
endmodule

// File: rtl/evt_timer16_dp.sv
module evt_timer16_dp
  import evt_timer16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  ctrlReg_t         ctrlQ,
  input  logic [1:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             ovfFlag
);
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] bufQ;
  logic wrap;

  assign wrap = strb.inc && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.wrLo || strb.wrHi) begin
      if (strb.wrLo)     cnt[BUS_W-1:0]     <= busWdata;
      if (strb.loadFull) cnt[CNT_W-1:BUS_W] <= bufQ;
      if (strb.wrHi)     cnt[CNT_W-1:BUS_W] <= busWdata;
    end else if (strb.clr) begin
      cnt <= '0;
    end else if (strb.inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufQ <= '0;
    else if (strb.wrBuf) bufQ <= busWdata;
    else if (strb.capBuf) bufQ <= cnt[CNT_W-1:BUS_W];
  end

  // set wins over software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (wrap) ovfFlag <= 1'b1;
    else if (strb.flagClr) ovfFlag <= 1'b0;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = BUS_W'(ctrlQ);
      ADDR_LO:   busRdata = cnt[BUS_W-1:0];
      ADDR_HI:   busRdata = ctrlQ.rw16 ? bufQ : cnt[CNT_W-1:BUS_W];
      default:   busRdata = BUS_W'(ovfFlag);
    endcase
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> (cnt == '0));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.inc |=> (cnt == $past(cnt) + 1'b1));

  // R3
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.inc && !strb.clr && !strb.wrLo && !strb.wrHi) |=> $stable(cnt));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strb.flagClr) |=> ovfFlag);

  // R8
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && !strb.clr && (cnt == {CNT_W{1'b1}})) |=> (ovfFlag && cnt == '0));

  // R10
  buf_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBuf |=> $stable(cnt) || $past(strb.inc));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int CYC_DIV = 4,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extIn,
  input  logic             cmpClear,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             ovfIrq
);
  ctrlReg_t  ctrlQ;
  dpStrobe_t strb;

  evt_timer16_ctrl #(.CYC_DIV(CYC_DIV), .SYNC_N(SYNC_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .extIn(extIn), .cmpClear(cmpClear),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWbits(busWdata[CTRL_W-1:0]), .ctrlQ(ctrlQ), .strb(strb)
  );

  evt_timer16_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlQ(ctrlQ),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .ovfFlag(ovfIrq)
  );
endmodule

// File: tb/evt_timer16_tb_top.sv
`timescale 1ns/1ps
module evt_timer16_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extIn = 1'b0;
  logic cmpClear = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic ovfIrq;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] EN = 8'h01, EXT = 8'h02, NOSYNC = 8'h10, RW16 = 8'h20;

  always #5 clk = ~clk;

  evt_timer16 dut_i (
    .clk(clk), .rstN(rstN), .extIn(extIn), .cmpClear(cmpClear),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .ovfIrq(ovfIrq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = busRdata;
  endtask

  // caller sits at a negedge; takes one cycle
  task automatic rd16(output logic [15:0] v);
    busAddr = 2'd1; busRd = 1'b1;
    #1 v[7:0] = busRdata;
    @(negedge clk);
    busRd = 1'b0; busAddr = 2'd2;
    #1 v[15:8] = busRdata;
  endtask

  task automatic load16(input logic [15:0] v);
    wr(2'd2, v[15:8]);
    wr(2'd1, v[7:0]);
  endtask

  task automatic pulse();
    @(negedge clk); extIn = 1'b1;
    @(negedge clk); extIn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    int cur;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), b);
      chk("R1", 16'(b), 16'h0);
    end
    chk("R1 irq", 16'(ovfIrq), 16'h0);

    // R12 control readback
    wr(2'd0, 8'h2D); @(negedge clk); peek(2'd0, b); chk("R12", 16'(b), 16'h2D);
    wr(2'd0, 8'hFF); peek(2'd0, b); chk("R12", 16'(b), 16'h3F);

    // R2 timer sweep over all prescaler settings
    for (int p = 0; p < 4; p++) begin
      int d;
      int tgt [5];
      d = 1 << p;
      tgt[0] = 4*d - 1; tgt[1] = 4*d; tgt[2] = 20*d - 1; tgt[3] = 20*d; tgt[4] = 300;
      wr(2'd0, EN | RW16 | 8'(p << 2));
      load16(16'h0000);
      cur = 0;
      for (int i = 0; i < 5; i++) begin
        while (cur < tgt[i]) begin @(negedge clk); cur++; end
        rd16(w);
        chk("R2", w, 16'(tgt[i] / (4*d)));
        cur++;
      end
    end

    // R3 enable low holds
    wr(2'd0, RW16);
    load16(16'h1234);
    repeat (60) @(negedge clk);
    rd16(w); chk("R3", w, 16'h1234);
    pulse(); pulse();
    rd16(w); chk("R3", w, 16'h1234);

    // R4 synchronized external path
    wr(2'd0, EN | EXT | RW16);
    load16(16'h0000);
    extIn = 1'b1;                      // first sampled at edge A
    @(negedge clk); peek(2'd1, b); chk("R4 A", 16'(b), 16'h0);
    @(negedge clk); peek(2'd1, b); chk("R4 A+1", 16'(b), 16'h0);
    @(negedge clk); peek(2'd1, b); chk("R4 A+2", 16'(b), 16'h1);
    extIn = 1'b0;
    repeat (4) @(negedge clk);
    peek(2'd1, b); chk("R4 single", 16'(b), 16'h1);

    // R5 direct external path
    wr(2'd0, EN | EXT | NOSYNC | RW16);
    load16(16'h0000);
    extIn = 1'b1;
    @(negedge clk); peek(2'd1, b); chk("R5 A", 16'(b), 16'h1);
    @(negedge clk); peek(2'd1, b); chk("R5 level", 16'(b), 16'h1);
    extIn = 1'b0;

    // R6 external prescaler sweep
    for (int p = 0; p < 4; p++) begin
      wr(2'd0, EN | EXT | NOSYNC | RW16 | 8'(p << 2));
      load16(16'h0000);
      for (int k = 1; k <= 16; k++) begin
        pulse();
        peek(2'd1, b);
        chk("R6", 16'(b), 16'(k >> p));
      end
    end

    // R7 clear beats increment
    wr(2'd0, EN | EXT | NOSYNC | RW16);
    load16(16'h0050);
    @(negedge clk); cmpClear = 1'b1; extIn = 1'b1;
    @(negedge clk); cmpClear = 1'b0; extIn = 1'b0;
    rd16(w); chk("R7 clear", w, 16'h0000);
    // R7 write beats clear
    wr(2'd2, 8'h00);
    @(negedge clk); busAddr = 2'd1; busWdata = 8'h77; busWr = 1'b1; cmpClear = 1'b1;
    @(negedge clk); busWr = 1'b0; cmpClear = 1'b0;
    rd16(w); chk("R7 write", w, 16'h0077);

    // R8 overflow flag
    wr(2'd3, 8'h01);
    load16(16'hFFFF);
    chk("R8 pre", 16'(ovfIrq), 16'h0);
    pulse();
    chk("R8 set", 16'(ovfIrq), 16'h1);
    peek(2'd3, b); chk("R8 stat", 16'(b), 16'h01);
    rd16(w); chk("R8 wrap", w, 16'h0000);
    repeat (10) @(negedge clk);
    chk("R8 sticky", 16'(ovfIrq), 16'h1);
    wr(2'd3, 8'h00); chk("R8 w0", 16'(ovfIrq), 16'h1);
    wr(2'd3, 8'h01); chk("R8 w1c", 16'(ovfIrq), 16'h0);
    load16(16'hFFFF);
    @(negedge clk); extIn = 1'b1; busAddr = 2'd3; busWdata = 8'h01; busWr = 1'b1;
    @(negedge clk); extIn = 1'b0; busWr = 1'b0;
    chk("R8 race", 16'(ovfIrq), 16'h1);
    wr(2'd3, 8'h01);

    // R9 atomic read snapshot
    load16(16'h00FF);
    busAddr = 2'd1; busRd = 1'b1;
    #1 b = busRdata; chk("R9 lo", 16'(b), 16'h00FF);
    @(negedge clk); busRd = 1'b0; extIn = 1'b1;
    @(negedge clk); extIn = 1'b0;
    peek(2'd2, b); chk("R9 buffered hi", 16'(b), 16'h00);
    rd16(w); chk("R9 live", w, 16'h0100);

    // R10 buffered write
    wr(2'd0, RW16);
    load16(16'h1234);
    wr(2'd2, 8'hAB);
    rd16(w); chk("R10 isolate", w, 16'h1234);
    wr(2'd2, 8'hAB);
    wr(2'd1, 8'hCD);
    rd16(w); chk("R10 load", w, 16'hABCD);

    // R11 direct byte access
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h12);
    peek(2'd2, b); chk("R11 hi", 16'(b), 16'h12);
    peek(2'd1, b); chk("R11 lo", 16'(b), 16'h34);
    wr(2'd2, 8'h56);
    peek(2'd1, b); chk("R11 lo kept", 16'(b), 16'h34);
    wr(2'd1, 8'h78);
    peek(2'd2, b); chk("R11 hi kept", 16'(b), 16'h56);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule